// File: doc/BRIEF.md
# Serial Scan Register Access Port

This block lets an external debugger reach a bank of 32-bit registers through a serial scan chain driven by a test access port controller. The controller itself lives outside: it presents one-cycle capture, shift and update strobes, the serial input bit, and the instruction currently held in its 4-bit instruction register. The block returns the serial output bit and drives a simple synchronous register bus with read and write strobes, a 7-bit address and 32 bits of write data.

Two instructions matter. The chain-select instruction turns the data path into a 5-bit register whose value is committed on update and names the chain that the access instruction reaches. With chain 0 selected, the access instruction connects a 40-bit word that carries data, address and direction together. A write is issued on update. A read is issued on update too, but its result is parked in a holding register and only leaves the chip in the data field of the following scan. With any other chain selected, the access instruction sees a 1-bit dummy stage. Every other instruction sees a 1-bit bypass stage.

Top module: `scan_regport`

## Requirements
- R1: After synchronous reset the chain select is 0, the read holding register is 0, and neither bus strobe is active.
- R2: The access word is 40 bits, shifted least significant bit first: bits 31..0 data, bits 38..32 register address, bit 39 direction (1 = write, 0 = read). On capture, the data field loads the holding register and bits 39..32 load 0.
- R3: An update of a write word drives `bus_wr` high for exactly the one clock after the update strobe, with `bus_addr` and `bus_wdata` taken from the shifted word.
- R4: An update of a read word drives `bus_rd` high for the one clock after the update strobe. `bus_rdata` is sampled into the holding register in that clock and is returned in the data field of the next scan.
- R5: Each read update gives exactly one `bus_rd` pulse, so a register that advances on every read advances once. A capture without an update gives no pulse.
- R6: Instruction 0x2 connects a 5-bit chain-select shift register. On capture it loads the current chain number, and on update the shifted value becomes the new chain number.
- R7: Instruction 0xC with a nonzero chain number connects a 1-bit dummy stage that captures 0. No bus strobe is issued.
- R8: Any instruction other than 0x2 and 0xC connects a 1-bit bypass stage that captures 0, with no bus strobe.
- R9: A write update leaves the holding register unchanged. The scan after a write returns the result of the last read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the controller strobes |
| rst | input | 1 | Synchronous active-high reset |
| ir_code | input | 4 | Current instruction from the external controller |
| tap_capture | input | 1 | One-cycle capture strobe for the data path |
| tap_shift | input | 1 | Shift enable, one bit per clock |
| tap_update | input | 1 | One-cycle update strobe for the data path |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, the LSB of the connected stage |
| bus_wr | output | 1 | Register-bus write strobe |
| bus_rd | output | 1 | Register-bus read strobe |
| bus_addr | output | 7 | Register-bus address |
| bus_wdata | output | 32 | Register-bus write data |
| bus_rdata | input | 32 | Register-bus read data, valid while `bus_rd` is high |

## Verification
The assertions rely on the controller's sequencing. Update strobes never occur on consecutive clocks. At least two idle clocks separate an update from the next capture. The instruction and chain number stay fixed from capture to update. Read data answers combinationally in the cycle of `bus_rd`. The stimulus tasks always end a scan with one update followed by two idle clocks. They change the instruction only between scans. The bench register-file model answers reads from its current contents and from an auto-advancing location at address 4.

// File: rtl/scan_regport_pkg.sv
package scan_regport_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int ACC_W   = DATA_W + ADDR_W + 1;
    localparam int IR_W    = 4;
    localparam int SEL_W   = 5;

    localparam logic [IR_W-1:0]  IR_CHAIN_SEL  = 4'h2;
    localparam logic [IR_W-1:0]  IR_REG_ACCESS = 4'hC;
    localparam logic [SEL_W-1:0] ACCESS_CHAIN  = '0;

    typedef enum logic [1:0] {
        PATH_BYPASS = 2'd0,
        PATH_SELECT = 2'd1,
        PATH_ACCESS = 2'd2,
        PATH_DUMMY  = 2'd3
    } path_e;

    typedef struct packed {
        logic cap;
        logic shf;
        logic upd;
    } strobe_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_word_t;

    function automatic path_e pick_path(input logic [IR_W-1:0] ir,
                                        input logic [SEL_W-1:0] sel);
        path_e p;
        if (ir == IR_CHAIN_SEL)
            p = PATH_SELECT;
        else if (ir == IR_REG_ACCESS)
            p = (sel == ACCESS_CHAIN) ? PATH_ACCESS : PATH_DUMMY;
        else
            p = PATH_BYPASS;
        return p;
    endfunction

    function automatic strobe_t gate_strobe(input strobe_t st, input logic en);
        return en ? st : '0;
    endfunction

endpackage

// File: rtl/scan_bit_cell.sv
module scan_bit_cell
    import scan_regport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t st,
    input  logic    tdi,
    output logic    tdo
);
    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst)
            bit_q <= 1'b0;
        else if (st.cap)
            bit_q <= 1'b0;
        else if (st.shf)
            bit_q <= tdi;
    end

    assign tdo = bit_q;

    // R7 R8
    cell_capture_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(st.cap) |-> (tdo == 1'b0));

endmodule

// File: rtl/scan_sel_chain.sv
module scan_sel_chain
    import scan_regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          st,
    input  logic             tdi,
    output logic             tdo,
    output logic [SEL_W-1:0] sel_q
);
    logic [SEL_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            sel_q <= ACCESS_CHAIN;
        end else begin
            if (st.cap)
                sr <= sel_q;
            else if (st.shf)
                sr <= {tdi, sr[SEL_W-1:1]};
            if (st.upd)
                sel_q <= sr;
        end
    end

    assign tdo = sr[0];

    // R6
    sel_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(st.upd) |-> (sel_q == $past(sr)));

    // R6
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(st.upd) |-> $stable(sel_q));

endmodule

// File: rtl/scan_access_chain.sv
module scan_access_chain
    import scan_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           st,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic [ACC_W-1:0]  sr;
    logic [DATA_W-1:0] hold_q;
    acc_word_t         word;
    acc_word_t         cap_word;

    assign word = acc_word_t'(sr);

    always_comb begin
        cap_word      = '0;
        cap_word.data = hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (st.cap)
            sr <= ACC_W'(cap_word);
        else if (st.shf)
            sr <= {tdi, sr[ACC_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            bus_wr <= st.upd &  word.wr;
            bus_rd <= st.upd & ~word.wr;
            if (st.upd) begin
                bus_addr  <= word.addr;
                bus_wdata <= word.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (bus_rd)
            hold_q <= bus_rdata;
    end

    assign tdo = sr[0];

    // R2
    capture_word_chk: assert property (@(posedge clk) disable iff (rst)
        $past(st.cap) |-> (word.data == $past(hold_q) && word.addr == '0 && !word.wr));

    // R3
    wr_after_update_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> $past(st.upd));

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_wr);

    // R4
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd) |-> (hold_q == $past(bus_rdata)));

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> !bus_rd);

    // R5
    rd_after_update_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> ($past(st.upd) && !$past(st.cap)));

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> $stable(hold_q));

    // R3 R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_wr, bus_rd}));

endmodule

// File: rtl/scan_regport.sv
module scan_regport
    import scan_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              tap_capture,
    input  logic              tap_shift,
    input  logic              tap_update,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    logic [SEL_W-1:0] sel_q;
    path_e            path;
    strobe_t          st_all;
    strobe_t          st_sel;
    strobe_t          st_acc;
    strobe_t          st_dum;
    strobe_t          st_byp;
    logic             tdo_sel;
    logic             tdo_acc;
    logic             tdo_dum;
    logic             tdo_byp;

    assign path   = pick_path(ir_code, sel_q);
    assign st_all = '{cap: tap_capture, shf: tap_shift, upd: tap_update};
    assign st_sel = gate_strobe(st_all, path == PATH_SELECT);
    assign st_acc = gate_strobe(st_all, path == PATH_ACCESS);
    assign st_dum = gate_strobe(st_all, path == PATH_DUMMY);
    assign st_byp = gate_strobe(st_all, path == PATH_BYPASS);

    scan_sel_chain i_sel (
        .clk   (clk),
        .rst   (rst),
        .st    (st_sel),
        .tdi   (tdi),
        .tdo   (tdo_sel),
        .sel_q (sel_q)
    );

    scan_access_chain i_acc (
        .clk       (clk),
        .rst       (rst),
        .st        (st_acc),
        .tdi       (tdi),
        .tdo       (tdo_acc),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    scan_bit_cell i_dummy (
        .clk (clk),
        .rst (rst),
        .st  (st_dum),
        .tdi (tdi),
        .tdo (tdo_dum)
    );

    scan_bit_cell i_bypass (
        .clk (clk),
        .rst (rst),
        .st  (st_byp),
        .tdi (tdi),
        .tdo (tdo_byp)
    );

    always_comb begin
        unique case (path)
            PATH_SELECT: tdo = tdo_sel;
            PATH_ACCESS: tdo = tdo_acc;
            PATH_DUMMY:  tdo = tdo_dum;
            default:     tdo = tdo_byp;
        endcase
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bus_wr && !bus_rd && sel_q == ACCESS_CHAIN));

    // R7 R8
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr || bus_rd) |-> ($past(ir_code) == IR_REG_ACCESS && $past(sel_q) == ACCESS_CHAIN));

endmodule

// File: tb/test_scan_regport.sv
module test_scan_regport;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {dir, addr, data, expected data field returned by this scan}
    localparam logic [71:0] VEC [NVEC] = '{
        {1'b1, 7'd1, 32'h1111_1111, 32'h0000_0000},
        {1'b1, 7'd2, 32'h2222_2222, 32'h0000_0000},
        {1'b0, 7'd1, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 7'd2, 32'h0000_0000, 32'h1111_1111},
        {1'b0, 7'd4, 32'h0000_0000, 32'h2222_2222},
        {1'b0, 7'd4, 32'h0000_0000, 32'hA000_0000},
        {1'b0, 7'd0, 32'h0000_0000, 32'hA000_0001},
        {1'b1, 7'd0, 32'hDEAD_BEEF, 32'h0000_0000},
        {1'b0, 7'd0, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 7'd5, 32'h0000_0000, 32'hDEAD_BEEF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ir_code = 4'hF;
    logic        tap_capture = 1'b0;
    logic        tap_shift = 1'b0;
    logic        tap_update = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        bus_wr;
    logic        bus_rd;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    logic [31:0] rf [8];
    logic [7:0]  ptr;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          adv_cnt = 0;
    int          total = 0;
    int          bad = 0;
    logic [39:0] dout;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_regport i_scan_regport (
        .clk         (clk),
        .rst         (rst),
        .ir_code     (ir_code),
        .tap_capture (tap_capture),
        .tap_shift   (tap_shift),
        .tap_update  (tap_update),
        .tdi         (tdi),
        .tdo         (tdo),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata)
    );

    // register-file model: address 4 advances on every read
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) rf[i] <= '0;
            ptr <= '0;
        end else begin
            if (bus_wr) rf[bus_addr[2:0]] <= bus_wdata;
            if (bus_rd && bus_addr == 7'd4) ptr <= ptr + 8'd1;
        end
    end

    always_comb bus_rdata = (bus_addr == 7'd4) ? (32'hA000_0000 | {24'd0, ptr})
                                                : rf[bus_addr[2:0]];

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_rd) rd_cnt++;
            if (bus_wr) wr_cnt++;
            if (bus_rd && bus_addr == 7'd4) adv_cnt++;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_scan(input int len, input logic [39:0] din, output logic [39:0] dq);
        dq = '0;
        @(negedge clk);
        tap_capture = 1'b1;
        @(negedge clk);
        tap_capture = 1'b0;
        tap_shift = 1'b1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i];
            #1 dq[i] = tdo;
            @(negedge clk);
        end
        tap_shift = 1'b0;
        tap_update = 1'b1;
        @(negedge clk);
        tap_update = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rd0;
        int wr0;
        logic [39:0] pat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 strobes", {62'd0, bus_wr, bus_rd}, 64'd0);
        check("R1 tdo", {63'd0, tdo}, 64'd0);
        ir_code = 4'h2;
        do_scan(5, 40'd0, dout);
        check("R1 R6 chain after reset", {24'd0, dout}, 64'd0);

        // R2 R3 R4 R5 R9 vector table
        ir_code = 4'hC;
        for (int k = 0; k < NVEC; k++) begin
            do_scan(40, VEC[k][71:32], dout);
            check("R4 data field", {32'd0, dout[31:0]}, {32'd0, VEC[k][31:0]});
            check("R2 upper field", {56'd0, dout[39:32]}, 64'd0);
        end
        check("R3 write count", 64'(wr_cnt), 64'd3);
        check("R5 read count", 64'(rd_cnt), 64'd7);
        check("R5 advance count", 64'(adv_cnt), 64'd2);

        // R5 capture alone gives no pulse
        rd0 = rd_cnt;
        @(negedge clk);
        tap_capture = 1'b1;
        @(negedge clk);
        tap_capture = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 capture only", 64'(rd_cnt), 64'(rd0));

        // R6 chain select capture and latch
        ir_code = 4'h2;
        do_scan(5, 40'd3, dout);
        check("R6 old chain", {24'd0, dout}, 64'd0);
        do_scan(5, 40'd3, dout);
        check("R6 new chain", {24'd0, dout}, 64'd3);

        // R7 dummy stage with nonzero chain
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        ir_code = 4'hC;
        pat = {1'b1, 7'd1, 32'hFFFF_0000};
        do_scan(40, pat, dout);
        check("R7 dummy shift", {24'd0, dout}, {24'd0, pat[38:0], 1'b0});
        check("R7 no strobes", 64'(rd_cnt + wr_cnt), 64'(rd0 + wr0));

        // R8 bypass
        ir_code = 4'h5;
        pat = 40'hA5_C3F0_0F96;
        do_scan(40, pat, dout);
        check("R8 bypass shift", {24'd0, dout}, {24'd0, pat[38:0], 1'b0});
        check("R8 no strobes", 64'(rd_cnt + wr_cnt), 64'(rd0 + wr0));

        // back to chain 0
        ir_code = 4'h2;
        do_scan(5, 40'd0, dout);
        check("R6 chain readback", {24'd0, dout}, 64'd3);
        ir_code = 4'hC;
        do_scan(40, {1'b0, 7'd1, 32'd0}, dout);
        check("R4 hold from table end", {32'd0, dout[31:0]}, 64'd0);
        do_scan(40, {1'b0, 7'd0, 32'd0}, dout);
        check("R7 dummy write ignored", {32'd0, dout[31:0]}, 64'h1111_1111);
        wr0 = wr_cnt;
        do_scan(40, {1'b1, 7'd3, 32'h3333_3333}, dout);
        check("R4 read before write", {32'd0, dout[31:0]}, 64'hDEAD_BEEF);
        check("R3 one write", 64'(wr_cnt), 64'(wr0 + 1));
        do_scan(40, {1'b0, 7'd3, 32'd0}, dout);
        check("R9 hold kept over write", {32'd0, dout[31:0]}, 64'hDEAD_BEEF);
        do_scan(40, {1'b0, 7'd0, 32'd0}, dout);
        check("R3 written value", {32'd0, dout[31:0]}, 64'h3333_3333);

        // R1 reset again clears chain select
        ir_code = 4'h2;
        do_scan(5, 40'd9, dout);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        do_scan(5, 40'd0, dout);
        check("R1 chain cleared", {24'd0, dout}, 64'd0);
        ir_code = 4'hC;
        do_scan(40, {1'b0, 7'd0, 32'd0}, dout);
        check("R1 hold cleared", {24'd0, dout}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule